// File: doc/BRIEF.md
# Three-Channel Auto-Reload Timer Bank

This block holds a set of independent up-counting timers (three by default, each 18 bits wide) behind a small register port. Software writes a reload value and a control word for each channel. The control word starts or stops the channel, picks its behaviour on overflow and enables its interrupt. A shared tick-enable input paces every running channel. Each channel advances by one on every clock cycle where the tick is high.

When a channel steps past its all-ones value, it raises a sticky status flag. What the counter does next depends on the mode. In interval mode it reloads and keeps going. In one-shot mode it stops. In free-run mode it wraps to zero and keeps going. Each interrupt output is the channel's flag gated by that channel's enable.

A narrower variant, such as a 16-bit channel, is the same logic with a different width parameter. The data bus is as wide as the counter.

Top module: `tmr_bank`

## Requirements
- R1: Writing the control register with bit 0 (run) set loads the channel's reload value into its counter and starts the channel. Writing it with bit 0 clear stops the channel, and the counter then holds its value even while tick is high.
- R2: A running channel adds one to its counter on each clock edge where tick is high. With tick low, the counter holds.
- R3: Stepping a running counter from all ones (2^CNT_W-1) is an overflow. An overflow sets the channel's status flag (status register bit 0) in every mode.
- R4: In interval mode (control bits 2:1 = 1), an overflow loads the reload value and the channel keeps running.
- R5: In one-shot mode (control bits 2:1 = 0), an overflow wraps the counter to zero and clears the run bit, so the counter stays at zero on later ticks.
- R6: In free-run mode (control bits 2:1 = 2, with code 3 behaving the same), an overflow wraps the counter to zero, the channel keeps running and the reload value is not used.
- R7: Writing status bit 0 as one clears the flag, and writing it as zero leaves the flag unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R8: Interrupt output bit i equals channel i's flag ANDed with its enable (control bit 3).
- R9: Writing the reload register while a channel runs leaves the counter unchanged. The new value is used only at the next load or interval reload.
- R10: Channels are independent. Addresses whose channel field is NUM_CH or above read as zero, and writes to them change nothing.
- R11: Register address = {channel index, register select[1:0]}. The registers are: select 0 reload (read/write), select 1 control (bit 0 run, bits 2:1 mode, bit 3 interrupt enable), select 2 counter (read-only) and select 3 status. After reset, every register reads zero and irq is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared count enable for all channels |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address {channel, select} |
| wrData | input | CNT_W | Write data |
| rdAddr | input | ADDR_W | Read address {channel, select} |
| rdData | output | CNT_W | Read data, combinational from rdAddr |
| irq | output | NUM_CH | Per-channel interrupt requests |

## Verification
The hardest case to reach from the ports is an overflow that lands in the same cycle as a software clear of the flag. A second hard case is any overflow at all, because an 18-bit counter started from zero needs about 262 thousand ticks to get there. The stimulus avoids the long wait by loading reload values a few steps below all ones, so every mode reaches its overflow within a handful of ticks. For the collision case, the bench raises tick and the status-clear write on the same edge while the counter sits at all ones.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_INTERVAL = 2'd1,
    MODE_FREE     = 2'd2,
    MODE_FREE_ALT = 2'd3
  } tmr_mode_e;

  // control -> datapath, one per channel
  typedef struct packed {
    logic      load;     // strobe: copy reload into counter
    logic      clrFlag;  // strobe: clear sticky flag
    logic      run;      // level: channel is counting
    tmr_mode_e mode;     // level: overflow behaviour
  } tmr_strb_t;

  localparam logic [1:0] SEL_RELOAD = 2'd0;
  localparam logic [1:0] SEL_CTRL   = 2'd1;
  localparam logic [1:0] SEL_COUNT  = 2'd2;
  localparam logic [1:0] SEL_STATUS = 2'd3;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 18,
  parameter int ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [CNT_W-1:0]              wrData,
  input  logic [ADDR_W-1:0]             rdAddr,
  output logic [CNT_W-1:0]              rdData,
  input  logic [NUM_CH-1:0]             chanOvf,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  chanCnt,
  input  logic [NUM_CH-1:0]             chanFlag,
  output tmr_strb_t                     chanStrb [NUM_CH],
  output logic [NUM_CH-1:0][CNT_W-1:0]  chanReload,
  output logic [NUM_CH-1:0]             chanIe
);

  localparam int CH_AW = ADDR_W - 2;

  logic [CH_AW-1:0] wrCh, rdCh;
  logic [1:0]       wrSel, rdSel;
  logic [NUM_CH-1:0][3:0] ctlWord;

  assign wrCh  = wrAddr[ADDR_W-1:2];
  assign wrSel = wrAddr[1:0];
  assign rdCh  = rdAddr[ADDR_W-1:2];
  assign rdSel = rdAddr[1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic             hit, wrReload, wrCtl, wrStat;
    logic             runQ, ieQ;
    tmr_mode_e        modeQ;
    logic [CNT_W-1:0] reloadQ;

    assign hit      = wrEn && (wrCh == CH_AW'(i));
    assign wrReload = hit && (wrSel == SEL_RELOAD);
    assign wrCtl    = hit && (wrSel == SEL_CTRL);
    assign wrStat   = hit && (wrSel == SEL_STATUS);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runQ    <= 1'b0;
        ieQ     <= 1'b0;
        modeQ   <= MODE_ONESHOT;
        reloadQ <= '0;
      end else begin
        if (wrReload) reloadQ <= wrData;
        if (wrCtl) begin
          runQ  <= wrData[0];
          modeQ <= tmr_mode_e'(wrData[2:1]);
          ieQ   <= wrData[3];
        end else if (chanOvf[i] && modeQ == MODE_ONESHOT) begin
          runQ <= 1'b0;
        end
      end
    end

    assign chanStrb[i]   = '{load: wrCtl && wrData[0], clrFlag: wrStat && wrData[0],
                             run: runQ, mode: modeQ};
    assign chanReload[i] = reloadQ;
    assign chanIe[i]     = ieQ;
    assign ctlWord[i]    = {ieQ, modeQ, runQ};
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rdCh == CH_AW'(i)) begin
        case (rdSel)
          SEL_RELOAD: rdData = chanReload[i];
          SEL_CTRL:   rdData = CNT_W'(ctlWord[i]);
          SEL_COUNT:  rdData = chanCnt[i];
          default:    rdData = CNT_W'(chanFlag[i]);
        endcase
      end
    end
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 18
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  tmr_strb_t                     chanStrb [NUM_CH],
  input  logic [NUM_CH-1:0][CNT_W-1:0]  chanReload,
  output logic [NUM_CH-1:0][CNT_W-1:0]  chanCnt,
  output logic [NUM_CH-1:0]             chanFlag,
  output logic [NUM_CH-1:0]             chanOvf
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    logic [CNT_W-1:0] cntQ;
    logic             flagQ, step, wrap;

    assign step = chanStrb[i].run && tick;
    assign wrap = step && (cntQ == CNT_TOP);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (chanStrb[i].load) begin
        cntQ <= chanReload[i];
      end else if (step) begin
        if (cntQ == CNT_TOP)
          cntQ <= (chanStrb[i].mode == MODE_INTERVAL) ? chanReload[i] : '0;
        else
          cntQ <= cntQ + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                   flagQ <= 1'b0;
      else if (wrap)               flagQ <= 1'b1;
      else if (chanStrb[i].clrFlag) flagQ <= 1'b0;
    end

    assign chanCnt[i]  = cntQ;
    assign chanFlag[i] = flagQ;
    assign chanOvf[i]  = wrap;
  end

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 18,
  parameter int ADDR_W = ((NUM_CH > 1) ? $clog2(NUM_CH) : 1) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic [NUM_CH-1:0] irq
);

  tmr_strb_t                    chanStrb [NUM_CH];
  logic [NUM_CH-1:0][CNT_W-1:0] chanReload, chanCnt;
  logic [NUM_CH-1:0]            chanFlag, chanOvf, chanIe;

  tmr_ctrl #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .chanOvf(chanOvf), .chanCnt(chanCnt),
    .chanFlag(chanFlag), .chanStrb(chanStrb), .chanReload(chanReload),
    .chanIe(chanIe)
  );

  tmr_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .chanStrb(chanStrb),
    .chanReload(chanReload), .chanCnt(chanCnt), .chanFlag(chanFlag),
    .chanOvf(chanOvf)
  );

  assign irq = chanFlag & chanIe;

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 18
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          tick,
  input tmr_strb_t                     strb [NUM_CH],
  input logic [NUM_CH-1:0][CNT_W-1:0]  reload,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cnt,
  input logic [NUM_CH-1:0]             flag
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_load_r1: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].load |=> cnt[i] == $past(reload[i]));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].run && tick && cnt[i] != CNT_TOP && !strb[i].load
      |=> cnt[i] == CNT_W'($past(cnt[i]) + 1'b1));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      !(strb[i].run && tick) && !strb[i].load |=> $stable(cnt[i]));

    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].run && tick && cnt[i] == CNT_TOP |=> flag[i]);

    p_interval_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].run && tick && cnt[i] == CNT_TOP && !strb[i].load &&
      strb[i].mode == MODE_INTERVAL |=> cnt[i] == $past(reload[i]) && strb[i].run);

    p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].run && tick && cnt[i] == CNT_TOP && !strb[i].load &&
      strb[i].mode == MODE_ONESHOT |=> cnt[i] == '0 && !strb[i].run);

    p_free_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
      strb[i].run && tick && cnt[i] == CNT_TOP && !strb[i].load &&
      (strb[i].mode == MODE_FREE || strb[i].mode == MODE_FREE_ALT)
      |=> cnt[i] == '0 && strb[i].run);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      flag[i] && !strb[i].clrFlag |=> flag[i]);
  end

endmodule

bind tmr_bank tmr_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .strb(chanStrb),
  .reload(chanReload), .cnt(chanCnt), .flag(chanFlag)
);

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;

  localparam int NUM_CH = 3;
  localparam int CNT_W  = 18;
  localparam int ADDR_W = 4;
  localparam logic [CNT_W-1:0] TOP = '1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tick = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [CNT_W-1:0]  wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [CNT_W-1:0]  rdData;
  logic [NUM_CH-1:0] irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  tmr_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_tmr_bank (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  function automatic logic [ADDR_W-1:0] ad(int ch, int sel);
    return ADDR_W'((ch << 2) | sel);
  endfunction

  task automatic check(string req, string what, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int ch, int sel, logic [CNT_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ad(ch, sel); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdChk(string req, int ch, int sel, logic [CNT_W-1:0] exp);
    rdAddr = ad(ch, sel);
    #1;
    check(req, $sformatf("ch%0d sel%0d", ch, sel), rdData, exp);
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic testReset();
    for (int c = 0; c < NUM_CH; c++)
      for (int s = 0; s < 4; s++) rdChk("R11", c, s, '0);
    check("R11", "irq after reset", CNT_W'(irq), '0);
  endtask

  task automatic testInterval();
    wr(0, 0, TOP - 2);
    wr(0, 1, 18'd11);               // run, interval, ie
    rdChk("R1", 0, 2, TOP - 2);
    rdChk("R11", 0, 1, 18'd11);
    ticks(2);
    rdChk("R2", 0, 2, TOP);
    check("R8", "irq0 before overflow", CNT_W'(irq[0]), 0);
    ticks(1);
    rdChk("R4", 0, 2, TOP - 2);
    rdChk("R3", 0, 3, 18'd1);
    check("R8", "irq0 after overflow", CNT_W'(irq[0]), 1);
    repeat (3) @(negedge clk);
    rdChk("R2", 0, 2, TOP - 2);
    wr(0, 0, TOP - 5);
    rdChk("R9", 0, 2, TOP - 2);
    rdChk("R9", 0, 0, TOP - 5);
    ticks(3);
    rdChk("R9", 0, 2, TOP - 5);
  endtask

  task automatic testClear();
    wr(0, 3, 18'd0);
    rdChk("R7", 0, 3, 18'd1);
    wr(0, 3, 18'd1);
    rdChk("R7", 0, 3, 18'd0);
    check("R8", "irq0 after clear", CNT_W'(irq[0]), 0);
  endtask

  task automatic testStop();
    wr(0, 1, 18'd10);               // stopped, interval, ie
    ticks(4);
    rdChk("R1", 0, 2, TOP - 5);
  endtask

  task automatic testOneShot();
    wr(1, 0, TOP - 1);
    wr(1, 1, 18'd9);                // run, one-shot, ie
    ticks(2);
    rdChk("R5", 1, 2, 18'd0);
    rdChk("R3", 1, 3, 18'd1);
    rdChk("R5", 1, 1, 18'd8);
    check("R8", "irq1 one-shot", CNT_W'(irq[1]), 1);
    ticks(3);
    rdChk("R5", 1, 2, 18'd0);
    rdChk("R10", 0, 2, TOP - 5);
  endtask

  task automatic testFreeRun();
    wr(2, 0, TOP - 1);
    wr(2, 1, 18'd5);                // run, free-run, no ie
    ticks(2);
    rdChk("R6", 2, 2, 18'd0);
    rdChk("R3", 2, 3, 18'd1);
    rdChk("R6", 2, 1, 18'd5);
    check("R8", "irq2 masked", CNT_W'(irq[2]), 0);
    ticks(3);
    rdChk("R6", 2, 2, 18'd3);
  endtask

  task automatic testAltModeCollision();
    wr(1, 3, 18'd1);
    wr(1, 0, TOP);
    wr(1, 1, 18'd7);                // run, mode code 3
    rdChk("R1", 1, 2, TOP);
    rdChk("R7", 1, 3, 18'd0);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; wrAddr = ad(1, 3); wrData = 18'd1;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    rdChk("R7", 1, 3, 18'd1);
    rdChk("R6", 1, 2, 18'd0);
    ticks(2);
    rdChk("R6", 1, 2, 18'd2);
  endtask

  task automatic testUnmapped();
    wr(3, 0, 18'd5);
    wr(3, 1, 18'd1);
    for (int s = 0; s < 4; s++) rdChk("R10", 3, s, '0);
    rdChk("R10", 0, 2, TOP - 5);
    rdChk("R10", 1, 2, 18'd2);
    rdChk("R10", 0, 0, TOP - 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInterval();
    testClear();
    testStop();
    testOneShot();
    testFreeRun();
    testAltModeCollision();
    testUnmapped();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule